// File: doc/BRIEF.md
# Zero-Crossing Event Generator

This block decides, once per commutation step of a sensorless brushless motor drive, when the back-EMF zero crossing has happened and emits a single-cycle event for it. There are two ways the event can arise. The first is a hardware detection taken from a comparator output. The second is a simulated event, where the step timer matches a programmable zero-crossing register.

A hardware sample only counts while PWM is driving the selected output group, either the low-side group or the high-side group. The sample must also show the polarity chosen for the step. A programmable number of such samples in a row is needed before the block declares a detection. The simulated path compares the step timer against the register. In addition, it re-examines the register when the D event of the step arrives, so that a value written too late still produces its event.

Neither path may act until the step's C and D events have both been seen. Whichever path fires first ends the step's search. A sticky flag and a maskable interrupt report every event. A hardware event also stores the timer value, so that later steps can be simulated from it.

Top module: `zc_event_gen`

## Requirements
- R1: No event can fire until both the C event and the D event of the current step have been recorded. `step_start_i` forgets both. Both pulses must be seen at clock edges before the one at which the normal sampling window is open.
- R2: A hardware sample is accepted only in a cycle where `pwm_on_i` is 1 and `pwm_grp_hi_i` equals `grp_sel_hi_i` (1 = high-side group, 0 = low-side group).
- R3: A hardware detection needs `max(flt_need_i,1)` accepted samples in a row with a matching comparator level. An accepted sample with the wrong level restarts the run from zero. Cycles with no accepted sample leave the run unchanged. `step_start_i` restarts the run.
- R4: A comparator level matches when `cmp_i` equals `zc_pol_i` (1: high level is the crossing, 0: low level is the crossing).
- R5: With `hw_en_i` = 1, a hardware detection loads `timer_i` of the deciding cycle into the zero-crossing register (`zreg_o`).
- R6: With `sim_en_i` = 1, inside the window an event fires in the cycle where `timer_i` equals the register.
- R7: With `sim_en_i` = 1, suppose the D pulse arrives after C and before this step's event, and the register is less than or equal to `timer_i` in that cycle. Then the event fires from that cycle and `timer_i` overwrites the register.
- R8: With both modes enabled, the earlier source produces the step's event. Sources that coincide produce one event.
- R9: At most one event per step. Later detections and matches are ignored until `step_start_i`.
- R10: `zc_pulse_o` is high for exactly one cycle, the cycle after the deciding clock edge. The same edge sets `zc_flag_o`. `flag_clr_i` clears the flag unless an event sets it in the same cycle. `zc_irq_o` is high when the flag is set and `irq_mask_i` is 1.
- R11: `zreg_wr_i` loads `zreg_wdata_i` into the register. A capture or overwrite from R5/R7 in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| step_start_i | input | 1 | Start of a new commutation step |
| ev_c_i | input | 1 | C event pulse of the step |
| ev_d_i | input | 1 | D event pulse of the step |
| cmp_i | input | 1 | Back-EMF comparator output |
| zc_pol_i | input | 1 | Comparator level that counts as a crossing |
| pwm_on_i | input | 1 | PWM on-time indicator |
| pwm_grp_hi_i | input | 1 | PWM currently applied on the high-side group |
| grp_sel_hi_i | input | 1 | Group on which sensing is allowed (1 = high side) |
| hw_en_i | input | 1 | Enable hardware detection and capture |
| sim_en_i | input | 1 | Enable simulated event |
| flt_need_i | input | FLT_W | Consecutive samples required (0 acts as 1) |
| timer_i | input | TMR_W | Step timer value |
| zreg_wr_i | input | 1 | Register write strobe |
| zreg_wdata_i | input | TMR_W | Register write data |
| flag_clr_i | input | 1 | Flag clear strobe |
| irq_mask_i | input | 1 | Interrupt enable |
| zc_pulse_o | output | 1 | Zero-crossing event pulse |
| zreg_o | output | TMR_W | Zero-crossing register value |
| zc_flag_o | output | 1 | Sticky event flag |
| zc_irq_o | output | 1 | Interrupt request |

## Verification
Two pairs of functions can meet in one cycle, and the bench provokes both.

The first pair is a filtered hardware detection and a simulated timer match. The bench sets the timer equal to the register in the same cycle that the last matching comparator sample arrives. It then checks that exactly one pulse appears, that the register holds the captured value, and that later matches and samples produce nothing.

The second pair is an event and a flag clear strobe. The bench issues the clear in the deciding cycle and checks that the flag stays set.

// File: rtl/zc_pkg.sv
package zc_pkg;

    // Source that decides the zero-crossing event in a cycle
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_HW   = 2'd1,
        SRC_SIM  = 2'd2,
        SRC_LATE = 2'd3
    } zc_src_e;

endpackage

// File: rtl/zc_hw_filter.sv
module zc_hw_filter #(
    parameter int FLT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             sample_i,
    input  logic             match_i,
    input  logic [FLT_W-1:0] need_i,
    output logic             hit_o
);
    localparam int CW = FLT_W + 1;

    logic [FLT_W-1:0] cnt_q, cnt_d;
    logic [CW-1:0]    need_eff;
    logic [CW-1:0]    cnt_inc;

    always_comb begin
        need_eff = (need_i == '0) ? CW'(1) : {1'b0, need_i};
        cnt_inc  = {1'b0, cnt_q} + CW'(1);
        hit_o    = sample_i && match_i && (cnt_inc >= need_eff);
        cnt_d    = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (sample_i) begin
            if (!match_i) begin
                cnt_d = '0;
            end else if (!hit_o) begin
                // below need_eff, so it fits in FLT_W bits
                cnt_d = cnt_inc[FLT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    AST_RUN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sample_i && !clr_i) |=> $stable(cnt_q)); // R3
    AST_RUN_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sample_i && !match_i) |=> (cnt_q == '0)); // R3

endmodule

// File: rtl/zc_sim_cmp.sv
module zc_sim_cmp #(
    parameter int TMR_W = 16
) (
    input  logic             sim_en_i,
    input  logic             win_i,
    input  logic             late_chk_i,
    input  logic [TMR_W-1:0] timer_i,
    input  logic [TMR_W-1:0] zreg_i,
    output logic             eq_hit_o,
    output logic             late_hit_o
);
    always_comb begin
        eq_hit_o   = sim_en_i && win_i && (timer_i == zreg_i);
        late_hit_o = sim_en_i && late_chk_i && (zreg_i <= timer_i);
    end
endmodule

// File: rtl/zc_event_gen.sv
module zc_event_gen
    import zc_pkg::*;
#(
    parameter int TMR_W = 16,
    parameter int FLT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_start_i,
    input  logic             ev_c_i,
    input  logic             ev_d_i,
    input  logic             cmp_i,
    input  logic             zc_pol_i,
    input  logic             pwm_on_i,
    input  logic             pwm_grp_hi_i,
    input  logic             grp_sel_hi_i,
    input  logic             hw_en_i,
    input  logic             sim_en_i,
    input  logic [FLT_W-1:0] flt_need_i,
    input  logic [TMR_W-1:0] timer_i,
    input  logic             zreg_wr_i,
    input  logic [TMR_W-1:0] zreg_wdata_i,
    input  logic             flag_clr_i,
    input  logic             irq_mask_i,
    output logic             zc_pulse_o,
    output logic [TMR_W-1:0] zreg_o,
    output logic             zc_flag_o,
    output logic             zc_irq_o
);
    typedef struct packed {
        logic             c_seen;
        logic             d_seen;
        logic             done;
        logic             pulse;
        logic             flag;
        logic [TMR_W-1:0] zreg;
    } st_t;

    st_t     s_q, s_d;
    zc_src_e src;
    logic    win, grp_ok, sample, match, late_chk, fire;
    logic    hw_hit, eq_hit, late_hit;

    always_comb begin
        win      = s_q.c_seen && s_q.d_seen && !s_q.done && !step_start_i;
        grp_ok   = pwm_on_i && (pwm_grp_hi_i == grp_sel_hi_i);
        sample   = win && hw_en_i && grp_ok;
        match    = (cmp_i == zc_pol_i);
        late_chk = ev_d_i && s_q.c_seen && !s_q.d_seen && !s_q.done && !step_start_i;
    end

    zc_hw_filter #(.FLT_W(FLT_W)) filt_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clr_i    (step_start_i),
        .sample_i (sample),
        .match_i  (match),
        .need_i   (flt_need_i),
        .hit_o    (hw_hit)
    );

    zc_sim_cmp #(.TMR_W(TMR_W)) simc_i (
        .sim_en_i   (sim_en_i),
        .win_i      (win),
        .late_chk_i (late_chk),
        .timer_i    (timer_i),
        .zreg_i     (s_q.zreg),
        .eq_hit_o   (eq_hit),
        .late_hit_o (late_hit)
    );

    always_comb begin
        if (hw_hit)        src = SRC_HW;
        else if (eq_hit)   src = SRC_SIM;
        else if (late_hit) src = SRC_LATE;
        else               src = SRC_NONE;
        fire = (src != SRC_NONE);

        s_d = s_q;
        if (step_start_i) begin
            s_d.c_seen = 1'b0;
            s_d.d_seen = 1'b0;
            s_d.done   = 1'b0;
        end else begin
            s_d.c_seen = s_q.c_seen | ev_c_i;
            s_d.d_seen = s_q.d_seen | ev_d_i;
            s_d.done   = s_q.done | fire;
        end
        s_d.pulse = fire;
        s_d.flag  = fire | (s_q.flag & ~flag_clr_i);
        unique case (src)
            SRC_HW, SRC_LATE: s_d.zreg = timer_i;
            default: if (zreg_wr_i) s_d.zreg = zreg_wdata_i;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign zc_pulse_o = s_q.pulse;
    assign zreg_o     = s_q.zreg;
    assign zc_flag_o  = s_q.flag;
    assign zc_irq_o   = s_q.flag & irq_mask_i;

    AST_WAIT_C: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !s_q.c_seen |=> !zc_pulse_o); // R1
    AST_WAIT_D: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!s_q.d_seen && !ev_d_i) |=> !zc_pulse_o); // R1
    AST_PWM_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pwm_on_i && !sim_en_i) |=> !zc_pulse_o); // R2
    AST_HW_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hw_hit |=> (zreg_o == $past(timer_i))); // R5
    AST_LATE_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (late_hit && !hw_hit && !eq_hit) |=> (zc_pulse_o && zreg_o == $past(timer_i))); // R7
    AST_ONE_PER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.done && !step_start_i) |=> !zc_pulse_o); // R9
    AST_FLAG_WITH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        zc_pulse_o |-> zc_flag_o); // R10
    AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_clr_i && !fire) |=> !zc_flag_o); // R10

endmodule

// File: tb/zc_event_gen_tb_top.sv
module zc_event_gen_tb_top;
    localparam int TW = 16;
    localparam int FW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step_start = 0, ev_c = 0, ev_d = 0, cmp = 0, pol = 1;
    logic pwm_on = 0, grp_hi = 1, sel_hi = 1, hw_en = 0, sim_en = 0;
    logic [FW-1:0] need = 1;
    logic [TW-1:0] timer = 0;
    logic zwr = 0;
    logic [TW-1:0] zwdata = 0;
    logic fclr = 0, mask = 0;
    logic zc_pulse, zc_flag, zc_irq;
    logic [TW-1:0] zreg;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    zc_event_gen #(.TMR_W(TW), .FLT_W(FW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .step_start_i(step_start),
        .ev_c_i(ev_c), .ev_d_i(ev_d), .cmp_i(cmp), .zc_pol_i(pol),
        .pwm_on_i(pwm_on), .pwm_grp_hi_i(grp_hi), .grp_sel_hi_i(sel_hi),
        .hw_en_i(hw_en), .sim_en_i(sim_en), .flt_need_i(need),
        .timer_i(timer), .zreg_wr_i(zwr), .zreg_wdata_i(zwdata),
        .flag_clr_i(fclr), .irq_mask_i(mask),
        .zc_pulse_o(zc_pulse), .zreg_o(zreg), .zc_flag_o(zc_flag), .zc_irq_o(zc_irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // new step: also clears the flag; comparator path idle
    task automatic new_step();
        pwm_on = 0; step_start = 1; fclr = 1;
        tick();
        step_start = 0; fclr = 0;
    endtask

    task automatic write_z(input logic [TW-1:0] v);
        zwr = 1; zwdata = v;
        tick();
        zwr = 0;
    endtask

    task automatic arm(input logic [TW-1:0] t_at_d);
        ev_c = 1;
        tick();
        ev_c = 0; ev_d = 1; timer = t_at_d;
        tick();
        ev_d = 0;
    endtask

    task automatic hw_cfg(input int n, input logic p);
        hw_en = 1; sim_en = 0; need = FW'(n); pol = p;
        grp_hi = 1; sel_hi = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog R9 actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        check("reset pulse R10", int'(zc_pulse), 0);
        check("reset flag R10", int'(zc_flag), 0);
        check("reset zreg R11", int'(zreg), 0);
        check("reset irq R10", int'(zc_irq), 0);

        // R1: no event before C and D
        hw_cfg(1, 1);
        new_step();
        pwm_on = 1; cmp = 1;
        for (int i = 0; i < 3; i++) begin
            tick();
            check("no C/D R1", int'(zc_pulse), 0);
        end
        ev_c = 1; tick(); ev_c = 0;
        tick();
        check("C only R1", int'(zc_pulse), 0);
        ev_d = 1; tick(); ev_d = 0;
        check("D cycle R1", int'(zc_pulse), 0);
        tick();
        check("after C and D R1", int'(zc_pulse), 1);

        // R3/R4: filter length and polarity sweep
        for (int n = 0; n <= 4; n++) begin
            for (int p = 0; p < 2; p++) begin
                int eff;
                eff = (n == 0) ? 1 : n;
                hw_cfg(n, p[0]);
                new_step();
                arm(0);
                pwm_on = 1;
                cmp = ~p[0];
                tick();
                check("wrong level R4", int'(zc_pulse), 0);
                cmp = p[0];
                for (int i = 1; i <= eff; i++) begin
                    tick();
                    check("filter run R3", int'(zc_pulse), (i == eff) ? 1 : 0);
                end
                tick();
                check("single event R9", int'(zc_pulse), 0);
            end
        end

        // R3: mismatch restarts run
        hw_cfg(3, 1);
        new_step(); arm(0);
        pwm_on = 1; cmp = 1; tick(); tick();
        cmp = 0; tick();
        cmp = 1; tick(); tick();
        check("restart R3", int'(zc_pulse), 0);
        tick();
        check("restart done R3", int'(zc_pulse), 1);

        // R3: unaccepted cycles hold the run
        new_step(); arm(0);
        pwm_on = 1; cmp = 1; tick();
        pwm_on = 0; cmp = 0; tick(); tick();
        pwm_on = 1; cmp = 1; tick();
        check("hold mid R3", int'(zc_pulse), 0);
        tick();
        check("hold done R3", int'(zc_pulse), 1);

        // R3: step start restarts run
        hw_cfg(2, 1);
        new_step(); arm(0);
        pwm_on = 1; cmp = 1; tick();
        new_step(); arm(0);
        pwm_on = 1; cmp = 1; tick();
        check("step restart R3", int'(zc_pulse), 0);
        tick();
        check("step restart done R3", int'(zc_pulse), 1);

        // R2: gating sweep
        for (int k = 0; k < 8; k++) begin
            hw_cfg(1, 1);
            new_step(); arm(0);
            sel_hi = k[0]; grp_hi = k[1];
            pwm_on = k[2]; cmp = 1;
            tick();
            check("pwm gating R2", int'(zc_pulse), int'(k[2] && (k[0] == k[1])));
        end

        // R5: capture
        hw_cfg(1, 1);
        new_step(); write_z(16'h0777); arm(5);
        timer = 16'h1234; pwm_on = 1; cmp = 1;
        tick();
        check("capture pulse R5", int'(zc_pulse), 1);
        check("capture value R5", int'(zreg), 16'h1234);

        // R6: timer equality
        hw_en = 0; sim_en = 1;
        new_step(); write_z(50); arm(10);
        check("no early R6", int'(zc_pulse), 0);
        for (int t = 40; t <= 60; t++) begin
            timer = TW'(t);
            tick();
            check("equality R6", int'(zc_pulse), (t == 50) ? 1 : 0);
        end
        check("zreg kept R6", int'(zreg), 50);

        // R7: late value check at D
        for (int j = 0; j < 5; j++) begin
            int zv;
            case (j)
                0: zv = 5;
                1: zv = 19;
                2: zv = 20;
                3: zv = 21;
                default: zv = 40;
            endcase
            hw_en = 0; sim_en = 1;
            new_step(); write_z(TW'(zv)); arm(20);
            check("late fire R7", int'(zc_pulse), (zv <= 20) ? 1 : 0);
            check("late value R7", int'(zreg), (zv <= 20) ? 20 : zv);
        end

        // R8: coincident sources -> one event
        hw_cfg(1, 1); sim_en = 1;
        new_step(); write_z(30); arm(10);
        timer = 30; pwm_on = 1; cmp = 1; fclr = 1;
        tick();
        fclr = 0;
        check("coincide pulse R8", int'(zc_pulse), 1);
        check("coincide zreg R8", int'(zreg), 30);
        check("set beats clear R10", int'(zc_flag), 1);
        tick();
        check("coincide once R9", int'(zc_pulse), 0);

        // R8: hardware first
        new_step(); write_z(30); arm(10);
        timer = 20; pwm_on = 1; cmp = 1;
        tick();
        check("hw first R8", int'(zc_pulse), 1);
        check("hw first zreg R8", int'(zreg), 20);
        timer = 30; tick();
        check("later match ignored R9", int'(zc_pulse), 0);

        // R8: simulated first
        new_step(); write_z(30); arm(10);
        timer = 30; pwm_on = 1; cmp = 0;
        tick();
        check("sim first R8", int'(zc_pulse), 1);
        cmp = 1; timer = 31; tick();
        check("later hw ignored R9", int'(zc_pulse), 0);
        check("zreg unchanged R9", int'(zreg), 30);

        // R10: flag, irq, clear
        check("flag set R10", int'(zc_flag), 1);
        mask = 0; #1;
        check("irq masked R10", int'(zc_irq), 0);
        mask = 1; #1;
        check("irq raised R10", int'(zc_irq), 1);
        fclr = 1; tick(); fclr = 0;
        check("flag clear R10", int'(zc_flag), 0);
        check("irq clear R10", int'(zc_irq), 0);
        mask = 0;

        // R11: write and precedence
        hw_cfg(1, 1);
        new_step();
        write_z(16'hABCD);
        check("write R11", int'(zreg), 16'hABCD);
        arm(3);
        timer = 16'h2222; zwr = 1; zwdata = 16'h1111; pwm_on = 1; cmp = 1;
        tick();
        zwr = 0;
        check("capture wins R11", int'(zreg), 16'h2222);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule